// File: doc/BRIEF.md
# Third-Order Fractional Divide-Value Modulator

This block feeds a multi-modulus feedback divider. On every reference tick it issues one integer divide value so that, over a long run, the average modulus equals an integer part plus a fraction. The fraction is the programmed fractional word plus half of its least significant step. The sequence comes from a cascade of three first-order error-feedback accumulators whose carries are differenced and summed. This pushes the quantization error toward high offset frequencies, where the loop filter removes it.

The divide setting is taken only on a load strobe. The load also clears every accumulator and every difference history register, so the sequence that follows a change of setting is always the same for the same words. An integer-only mode holds the divide value fixed at the integer word. The fractional machinery stays frozen in that mode.

The output is an unsigned value. It is saturated to a legal modulus window given by two parameters, and a flag marks any step in which the unclamped value fell outside that window.

Top module: `fbMashMod`

## Requirements
- R1: After reset `divOut`, `divValid` and `rangeErr` are 0, and no reference tick produces a valid value until the first load.
- R2: A load (`loadStb` = 1 at a clock edge) captures `intWord`, `fracWord` and `intOnly`. The first divide value produced after a load equals the captured integer word. Changes on the word inputs without a load have no effect.
- R3: `divValid` is 1 in exactly the cycle after an edge that sampled `refTick` = 1 while loaded and with no load. `divOut` and `rangeErr` change only at such edges and hold otherwise.
- R4: With a fractional word F of width W, the sum of the 2^(W+1) divide values following a load equals MINT·2^(W+1) + 2F + 1 + e, with e in −1..+2.
- R5: In fractional mode every divide value differs from the integer word by −3..+4, unless it was saturated.
- R6: When the load captured `intOnly` = 1, every divide value equals the captured integer word (clamped), whatever the fractional word holds.
- R7: A divide value whose unclamped value is below DIV_MIN or above DIV_MAX is output as that bound, and `rangeErr` is 1 for that step. Otherwise `rangeErr` is 0.
- R8: Two loads of the same words yield identical divide-value sequences.
- R9: A load and a reference tick in the same cycle act as a load only: `divValid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Request for the next divide value |
| loadStb | input | 1 | Capture new words and restart the modulator |
| intOnly | input | 1 | Integer-only mode, captured on load |
| intWord | input | INT_W (7) | Integer part of the ratio |
| fracWord | input | FRAC_W (18) | Fractional part of the ratio |
| divOut | output | OUT_W (8) | Divide value for the current reference period |
| divValid | output | 1 | Pulse marking a new divide value |
| rangeErr | output | 1 | Divide value was clamped to the legal window |

## Verification
The averaging rule is tried with a zero fractional word, an all-ones word, a mid-scale power-of-two word and an irregular word, each on a narrow instance whose full period fits the run. The zero and all-ones cases separate a missing half-step offset from a wrong carry weighting, and the irregular word exposes stage-order errors. Integer-only loads, loads that push the value into each bound, back-to-back reloads of one setting and tick gaps then tell apart freezing, clamping, restart and hold behaviour.

// File: rtl/fbMashPkg.sv
package fbMashPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic clr;   // restart with new words
    logic step;  // produce the next divide value
    logic hold;  // integer-only mode active
  } mashStb_t;

  localparam int STAGES = 3;
endpackage

// File: rtl/fbMashCtrl.sv
module fbMashCtrl
  import fbMashPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadStb,
  input  logic     refTick,
  input  logic     intOnly,
  output mashStb_t stb,
  output logic     divValid
);
  logic armed;
  logic intMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      intMode  <= 1'b0;
      divValid <= 1'b0;
    end else begin
      divValid <= 1'b0;
      if (loadStb) begin
        armed   <= 1'b1;
        intMode <= intOnly;
      end else if (refTick && armed) begin
        divValid <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.clr  = loadStb;
    stb.step = refTick && armed && !loadStb;
    stb.hold = intMode;
  end
endmodule

// File: rtl/fbMashPath.sv
module fbMashPath
  import fbMashPkg::*;
#(
  parameter int INT_W   = 7,
  parameter int FRAC_W  = 18,
  parameter int OUT_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  mashStb_t          stb,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  output logic [OUT_W-1:0]  divOut,
  output logic              rangeErr,
  output logic [INT_W-1:0]  intCfg
);
  localparam int ACC_W = FRAC_W + 1;
  localparam int RAW_W = OUT_W + 2;
  localparam logic signed [RAW_W-1:0] LO_LIM = RAW_W'(DIV_MIN);
  localparam logic signed [RAW_W-1:0] HI_LIM = RAW_W'(DIV_MAX);

  logic [INT_W-1:0]  intReg;
  logic [ACC_W-1:0]  incReg;
  logic [ACC_W-1:0]  accD [STAGES];
  logic [STAGES-1:0] carry;
  logic c2Prev, c3Prev, c3Prev2;

  // Cascade of error-feedback accumulators; each later stage adds the
  // freshly updated residue of the stage before it.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [ACC_W-1:0] accQ;
    logic [ACC_W-1:0] stageIn;
    logic [ACC_W:0]   wideSum;
    if (s == 0) begin : g_first
      assign stageIn = incReg;
    end else begin : g_next
      assign stageIn = accD[s-1];
    end
    assign wideSum  = {1'b0, accQ} + {1'b0, stageIn};
    assign accD[s]  = wideSum[ACC_W-1:0];
    assign carry[s] = wideSum[ACC_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     accQ <= '0;
      else if (stb.clr)              accQ <= '0;
      else if (stb.step && !stb.hold) accQ <= accD[s];
    end
  end

  // Noise-shaped carry combination: c1 + d(c2) + d2(c3)
  logic signed [3:0] ofs;
  always_comb begin
    ofs = 4'sd0;
    if (!stb.hold) begin
      ofs = $signed({3'b000, carry[0]})
          + $signed({3'b000, carry[1]})
          - $signed({3'b000, c2Prev})
          + $signed({3'b000, carry[2]})
          - $signed({2'b00, c3Prev, 1'b0})
          + $signed({3'b000, c3Prev2});
    end
  end

  logic signed [RAW_W-1:0] rawDiv;
  logic [OUT_W-1:0]        clampDiv;
  logic                    outOfWin;
  always_comb begin
    rawDiv = $signed({{(RAW_W-INT_W){1'b0}}, intReg}) + $signed({{(RAW_W-4){ofs[3]}}, ofs});
    outOfWin = 1'b0;
    if (rawDiv < LO_LIM) begin
      clampDiv = OUT_W'(DIV_MIN);
      outOfWin = 1'b1;
    end else if (rawDiv > HI_LIM) begin
      clampDiv = OUT_W'(DIV_MAX);
      outOfWin = 1'b1;
    end else begin
      clampDiv = rawDiv[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReg   <= '0;
      incReg   <= '0;
      c2Prev   <= 1'b0;
      c3Prev   <= 1'b0;
      c3Prev2  <= 1'b0;
      divOut   <= '0;
      rangeErr <= 1'b0;
    end else if (stb.clr) begin
      intReg  <= intWord;
      incReg  <= {fracWord, 1'b1};
      c2Prev  <= 1'b0;
      c3Prev  <= 1'b0;
      c3Prev2 <= 1'b0;
    end else if (stb.step) begin
      divOut   <= clampDiv;
      rangeErr <= outOfWin;
      if (!stb.hold) begin
        c2Prev  <= carry[1];
        c3Prev2 <= c3Prev;
        c3Prev  <= carry[2];
      end
    end
  end

  assign intCfg = intReg;
endmodule

// File: rtl/fbMashMod.sv
module fbMashMod
  import fbMashPkg::*;
#(
  parameter int INT_W   = 7,
  parameter int FRAC_W  = 18,
  parameter int OUT_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              loadStb,
  input  logic              intOnly,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  output logic [OUT_W-1:0]  divOut,
  output logic              divValid,
  output logic              rangeErr
);
  mashStb_t         ctlStb;
  logic [INT_W-1:0] cfgInt;

  fbMashCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .refTick(refTick),
    .intOnly(intOnly), .stb(ctlStb), .divValid(divValid)
  );

  fbMashPath #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W),
    .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
  ) path_i (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .intWord(intWord),
    .fracWord(fracWord), .divOut(divOut), .rangeErr(rangeErr), .intCfg(cfgInt)
  );
endmodule

// File: rtl/fbMashChk.sv
module fbMashChk #(
  parameter int INT_W   = 7,
  parameter int OUT_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 255
) (
  input logic             clk,
  input logic             rstN,
  input logic             refTick,
  input logic             loadStb,
  input logic             divValid,
  input logic             rangeErr,
  input logic [OUT_W-1:0] divOut,
  input logic [INT_W-1:0] intReg,
  input logic             holdMode
);
  // R3
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    divValid |-> ($past(refTick) && !$past(loadStb)));

  // R9
  load_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !divValid);

  // R7
  out_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    divValid |-> (int'(divOut) >= DIV_MIN && int'(divOut) <= DIV_MAX));

  // R7
  err_at_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |-> (int'(divOut) == DIV_MIN || int'(divOut) == DIV_MAX));

  // R5
  offset_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divValid && !rangeErr) |->
      (int'(divOut) >= int'(intReg) - 3 && int'(divOut) <= int'(intReg) + 4));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divValid && $past(divValid) && holdMode) |-> $stable(divOut));
endmodule

bind fbMashMod fbMashChk #(
  .INT_W(INT_W), .OUT_W(OUT_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) chk_i (
  .clk(clk), .rstN(rstN), .refTick(refTick), .loadStb(loadStb),
  .divValid(divValid), .rangeErr(rangeErr), .divOut(divOut),
  .intReg(cfgInt), .holdMode(ctlStb.hold)
);

// File: tb/fbMashMod_tb_top.sv
module fbMashMod_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz
  logic rstN = 1'b0;

  // full-width instance
  logic refA = 0, loadA = 0, intA = 0;
  logic [6:0]  mintA = '0;
  logic [17:0] fracA = '0;
  logic [7:0]  outA;
  logic        vA, eA;
  // narrow instance: period 2^7 fits the run
  logic refB = 0, loadB = 0, intB = 0;
  logic [6:0] mintB = '0;
  logic [5:0] fracB = '0;
  logic [7:0] outB;
  logic       vB, eB;

  fbMashMod dut_i (.clk(clk), .rstN(rstN), .refTick(refA), .loadStb(loadA),
    .intOnly(intA), .intWord(mintA), .fracWord(fracA),
    .divOut(outA), .divValid(vA), .rangeErr(eA));

  fbMashMod #(.FRAC_W(6), .DIV_MIN(4), .DIV_MAX(60)) dutNarrow_i (.clk(clk),
    .rstN(rstN), .refTick(refB), .loadStb(loadB), .intOnly(intB),
    .intWord(mintB), .fracWord(fracB), .divOut(outB), .divValid(vB), .rangeErr(eB));

  int checks = 0;
  int errs   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doLoadA(input int m, input int f, input bit io);
    mintA = 7'(m); fracA = 18'(f); intA = io; loadA = 1;
    @(posedge clk); @(negedge clk);
    loadA = 0;
  endtask

  task automatic doLoadB(input int m, input int f, input bit io);
    mintB = 7'(m); fracB = 6'(f); intB = io; loadB = 1;
    @(posedge clk); @(negedge clk);
    loadB = 0;
  endtask

  task automatic tickA();
    refA = 1; @(posedge clk); @(negedge clk); refA = 0;
  endtask

  task automatic tickB();
    refB = 1; @(posedge clk); @(negedge clk); refB = 0;
  endtask

  // {integer word, fractional word, integer-only}
  localparam int VEC [6][3] = '{
    '{10, 0, 0}, '{10, 63, 0}, '{33, 21, 0}, '{50, 32, 0}, '{20, 5, 1}, '{41, 44, 0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int sum, lo, hi, exp, d, bad, errSeen, hiOut;
    int seq1 [8];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(outA == 0 && vA == 0 && eA == 0, "R1 reset outputs", {outA, vA, eA}, 0);
    rstN = 1;
    @(negedge clk);
    tickA();
    check(vA == 0, "R1 no value before load", vA, 0);

    // R4 R5 R2 R6 table walk on the narrow instance
    for (int v = 0; v < 6; v++) begin
      doLoadB(VEC[v][0], VEC[v][1], VEC[v][2] != 0);
      sum = 0; lo = 99; hi = -99; bad = 0;
      for (int k = 0; k < 128; k++) begin
        tickB();
        if (k == 0) check(int'(outB) == VEC[v][0], "R2 first value after load", outB, VEC[v][0]);
        if (!vB) bad++;
        d = int'(outB) - VEC[v][0];
        if (d < lo) lo = d;
        if (d > hi) hi = d;
        sum += int'(outB);
      end
      check(bad == 0, "R3 valid on every tick", bad, 0);
      if (VEC[v][2] != 0) begin
        exp = VEC[v][0] * 128;
        check(lo == 0 && hi == 0, "R6 integer mode constant", hi - lo, 0);
        check(sum == exp, "R6 integer mode sum", sum, exp);
      end else begin
        exp = VEC[v][0] * 128 + 2 * VEC[v][1] + 1;
        check(lo >= -3 && hi <= 4, "R5 offset span", (lo >= -3) ? hi : lo, 0);
        check(sum >= exp - 1 && sum <= exp + 2, "R4 average over period", sum, exp);
      end
    end

    // R7 upper clamp on the narrow instance
    doLoadB(60, 40, 0);
    errSeen = 0; hiOut = 0; bad = 0;
    for (int k = 0; k < 128; k++) begin
      tickB();
      if (int'(outB) > hiOut) hiOut = int'(outB);
      if (eB) errSeen++;
      if (eB && outB != 60) bad++;
    end
    check(hiOut == 60, "R7 upper clamp", hiOut, 60);
    check(errSeen > 0 && bad == 0, "R7 flag on clamp", errSeen, 1);

    // R2 R3 full-width instance
    doLoadA(100, 18'h2AAAA, 0);
    check(vA == 0, "R3 no valid after load", vA, 0);
    tickA();
    check(outA == 100 && vA == 1, "R2 first value full width", outA, 100);
    d = int'(outA);
    repeat (3) @(negedge clk);
    check(vA == 0 && int'(outA) == d, "R3 hold between ticks", outA, d);
    mintA = 7'd5;
    tickA();
    check(outA >= 97 && outA <= 104, "R2 word ignored without load", outA, 100);

    // R8 restart determinism
    doLoadA(100, 18'h2AAAA, 0);
    for (int k = 0; k < 8; k++) begin tickA(); seq1[k] = int'(outA); end
    doLoadA(100, 18'h2AAAA, 0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin tickA(); if (int'(outA) != seq1[k]) bad++; end
    check(bad == 0, "R8 repeatable sequence", bad, 0);

    // R9 load wins over tick
    refA = 1; loadA = 1; mintA = 7'd90; fracA = 18'h1; intA = 0;
    @(posedge clk); @(negedge clk);
    refA = 0; loadA = 0;
    check(vA == 0, "R9 load priority", vA, 0);
    tickA();
    check(outA == 90, "R9 load taken", outA, 90);

    // R6 integer mode on full width, fractional word moved
    doLoadA(77, 18'h3FFFF, 1);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      fracA = 18'(k * 9001);
      tickA();
      if (outA != 77) bad++;
    end
    check(bad == 0, "R6 integer mode holds", bad, 0);

    // R7 lower clamp
    doLoadA(2, 0, 1);
    tickA();
    check(outA == 4 && eA == 1, "R7 lower clamp", outA, 4);
    doLoadA(127, 0, 1);
    tickA();
    check(outA == 127 && eA == 0, "R7 in window no flag", {eA, outA}, 127);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule